// File: doc/BRIEF.md
# Half-Duplex Echo-Checking Turnaround Controller

This block owns the bus-direction control of a node on a shared two-wire half-duplex line. The node's receiver is never switched off while it transmits, so every byte it sends comes back on its own receive path. The block keeps each byte handed to the transmitter in a small pending queue. While it is in echo mode, it pairs each byte heard on the receive path with the oldest pending byte. Echoed bytes are never passed on as incoming data.

The driver is released by hearing the node's own traffic, not by a transmit-side timer or status bit. When the echo of the byte marked last comes back and nothing else is pending, driver enable drops on the next clock edge. The receive path returns to normal mode at the same edge, and later bytes are forwarded to the consumer. A wrong echo, or a framing error during echo, raises a sticky collision flag. If the line goes quiet for a programmable number of cycles while echoes are still expected, the driver is released anyway, the pending queue is emptied and a sticky timeout flag is raised. The serial transmitter and receiver are separate blocks that signal each byte with a one-cycle valid strobe. The receive strobe is expected on the stop bit of each byte, without any buffering delay.

Top module: `echo_turnaround_ctrl`

## Requirements
- R1: After reset, drv_en and echo_mode are 0, dout_valid is 0, and collision_flag and timeout_flag are 0.
- R2: A transmit byte accepted while pend_full is 0 makes drv_en and echo_mode 1 from the next clock edge.
- R3: A byte received while echo_mode is 1 never produces dout_valid.
- R4: When the echo of a byte sent with tx_last=1 is received and no other byte is pending or being accepted, drv_en and echo_mode go to 0 at the clock edge that samples that receive strobe.
- R5: In normal mode, a received byte with rx_frame_err=0 appears on dout_data with dout_valid=1 for one cycle, one edge after its strobe. A byte with rx_frame_err=1 is dropped.
- R6: An echoed byte that differs from the oldest pending byte sets collision_flag. Driver enable is still released when the last byte's echo slot is consumed.
- R7: A framing error on a byte received in echo mode sets collision_flag, even when the data bits match.
- R8: collision_flag and timeout_flag hold until a transmit byte is accepted while drv_en is 0. That edge clears both.
- R9: While echo_mode is 1, once timeout_cycles edges have passed with no receive strobe and no accepted transmit byte, the following edge clears drv_en and echo_mode, empties the queue and sets timeout_flag.
- R10: The queue holds DEPTH bytes. pend_full is 1 when DEPTH bytes are pending, and a transmit byte offered while it is 1 is ignored.
- R11: Echoes are matched in transmission order. The same bytes echoed in a different order set collision_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Byte handed to the transmitter this cycle |
| tx_data | input | DATA_W | Byte handed to the transmitter |
| tx_last | input | 1 | Marks the final byte of a message |
| pend_full | output | 1 | Pending-echo queue is full |
| rx_valid | input | 1 | Received byte strobe, on the byte's stop bit |
| rx_data | input | DATA_W | Received byte |
| rx_frame_err | input | 1 | Received byte had a bad stop bit |
| timeout_cycles | input | TO_W | Quiet cycles allowed before a forced release |
| drv_en | output | 1 | Line driver enable |
| echo_mode | output | 1 | Receive path is checking echoes |
| dout_valid | output | 1 | Incoming byte delivered to the consumer |
| dout_data | output | DATA_W | Delivered byte |
| collision_flag | output | 1 | Sticky echo mismatch or framing error |
| timeout_flag | output | 1 | Sticky echo timeout |

## Verification
The bench builds the block with DATA_W=8, DEPTH=4 and TO_W=16, and drives timeout_cycles to 10. At DEPTH=4 the queue fills after only four bytes, which puts the ignored fifth byte and the full indication within easy reach. The power-of-two depth also selects the natural-wrap pointer variant. A 10-cycle quiet window makes the exact release edge of the timeout path observable: drv_en is still high after ten idle edges and low after eleven. A message that fills the queue without a last marker has to end through that path.

// File: rtl/echo_ta_pkg.sv
package echo_ta_pkg;

   // Receive-path mode; the driver is enabled exactly while checking echoes.
   typedef enum logic {
      PATH_NORMAL = 1'b0,
      PATH_ECHO   = 1'b1
   } rx_path_e;

endpackage

// File: rtl/echo_pend_fifo.sv
module echo_pend_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [W-1:0]                  wdata,
   input  logic                          pop,
   input  logic                          flush,
   output logic [W-1:0]                  head,
   output logic                          empty,
   output logic                          full,
   output logic [$clog2(DEPTH+1)-1:0]    count
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 4) begin : g_depth_chk
         $error("echo_pend_fifo: DEPTH must be at least 4");
      end
      if (W < 2) begin : g_width_chk
         $error("echo_pend_fifo: W must hold data and a last marker");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];
   assign count   = cnt_q;

   generate
      if ((1 << PW) == DEPTH) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assert_fifo_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   assert_fifo_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (cnt_q == CW'(DEPTH)));

endmodule

// File: rtl/echo_silence_timer.sv
module echo_silence_timer #(
   parameter int TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            armed,
   input  logic            activity,
   input  logic [TO_W-1:0] limit,
   output logic            expire
);
   generate
      if (TO_W < 2) begin : g_to_chk
         $error("echo_silence_timer: TO_W must be at least 2");
      end
   endgenerate

   logic [TO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (!armed || activity) cnt_q <= '0;
      else if (cnt_q != '1)       cnt_q <= cnt_q + 1'b1;
   end

   assign expire = armed && !activity && (cnt_q >= limit);

endmodule

// File: rtl/echo_turnaround_ctrl.sv
module echo_turnaround_ctrl
   import echo_ta_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int DEPTH          = 4,
   parameter int TO_W           = 16,
   parameter bit DROP_ERR_BYTES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_last,
   output logic              pend_full,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_frame_err,
   input  logic [TO_W-1:0]   timeout_cycles,
   output logic              drv_en,
   output logic              echo_mode,
   output logic              dout_valid,
   output logic [DATA_W-1:0] dout_data,
   output logic              collision_flag,
   output logic              timeout_flag
);
   localparam int EW = DATA_W + 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_dw_chk
         $error("echo_turnaround_ctrl: DATA_W must be a serial character width 5..9");
      end
   endgenerate

   rx_path_e          path_q;
   logic              echo_on;
   logic              tx_take, echo_rx, do_pop, mismatch, release_last, msg_start;
   logic              expire, deliver, q_empty, q_full;
   logic [EW-1:0]     q_head;
   logic [DATA_W-1:0] head_data;
   logic              head_last;
   logic [CW-1:0]     q_count;
   logic              coll_q, tmo_q, dv_q;
   logic [DATA_W-1:0] dd_q;

   assign echo_on   = (path_q == PATH_ECHO);
   assign tx_take   = tx_valid && !q_full;
   assign msg_start = tx_take && !echo_on;
   assign echo_rx   = rx_valid && echo_on;
   assign do_pop    = echo_rx && !q_empty;
   assign {head_last, head_data} = q_head;

   assign mismatch     = echo_rx && (q_empty || rx_frame_err || (head_data != rx_data));
   assign release_last = do_pop && head_last && (q_count == CW'(1)) && !tx_take;

   echo_pend_fifo #(.W(EW), .DEPTH(DEPTH)) pend_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_take),
      .wdata ({tx_last, tx_data}),
      .pop   (do_pop),
      .flush (expire),
      .head  (q_head),
      .empty (q_empty),
      .full  (q_full),
      .count (q_count)
   );

   echo_silence_timer #(.TO_W(TO_W)) quiet_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (echo_on),
      .activity (tx_take || rx_valid),
      .limit    (timeout_cycles),
      .expire   (expire)
   );

   // Direction and receive-path mode switch together.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            path_q <= PATH_NORMAL;
      else if (expire)       path_q <= PATH_NORMAL;
      else if (tx_take)      path_q <= PATH_ECHO;
      else if (release_last) path_q <= PATH_NORMAL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coll_q <= 1'b0;
         tmo_q  <= 1'b0;
      end else if (msg_start) begin
         coll_q <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         if (mismatch) coll_q <= 1'b1;
         if (expire)   tmo_q  <= 1'b1;
      end
   end

   generate
      if (DROP_ERR_BYTES) begin : g_drop_err
         assign deliver = rx_valid && !echo_on && !rx_frame_err;
      end else begin : g_keep_err
         assign deliver = rx_valid && !echo_on;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q <= 1'b0;
         dd_q <= '0;
      end else begin
         dv_q <= deliver;
         if (deliver) dd_q <= rx_data;
      end
   end

   assign pend_full      = q_full;
   assign drv_en         = echo_on;
   assign echo_mode      = echo_on;
   assign dout_valid     = dv_q;
   assign dout_data      = dd_q;
   assign collision_flag = coll_q;
   assign timeout_flag   = tmo_q;

   assert_drive_after_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !pend_full) |=> drv_en);

   assert_no_echo_delivery_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> ($past(rx_valid) && !$past(echo_mode)));

   assert_release_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_en) |-> ($past(rx_valid) || $past(expire)));

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (collision_flag && !(tx_valid && !drv_en)) |=> collision_flag);

   assert_timeout_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_flag) |-> $fell(drv_en));

endmodule

// File: tb/echo_turnaround_ctrl_tb.sv
module echo_turnaround_ctrl_tb_top;
   localparam int DW = 8;
   localparam int TO = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_valid = 1'b0, tx_last = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic          rx_valid = 1'b0, rx_frame_err = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic [15:0]   timeout_cycles = 16'(TO);
   logic          pend_full, drv_en, echo_mode, dout_valid, collision_flag, timeout_flag;
   logic [DW-1:0] dout_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   echo_turnaround_ctrl #(.DATA_W(DW), .DEPTH(4), .TO_W(16)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .pend_full(pend_full),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
      .timeout_cycles(timeout_cycles),
      .drv_en(drv_en), .echo_mode(echo_mode),
      .dout_valid(dout_valid), .dout_data(dout_data),
      .collision_flag(collision_flag), .timeout_flag(timeout_flag)
   );

   // {tx byte, echoed byte, framing error, expected collision}
   localparam logic [17:0] VECS [6] = '{
      {8'hA5, 8'hA5, 1'b0, 1'b0},
      {8'h3C, 8'h3D, 1'b0, 1'b1},
      {8'h00, 8'h00, 1'b1, 1'b1},
      {8'hFF, 8'hFF, 1'b0, 1'b0},
      {8'h81, 8'h01, 1'b0, 1'b1},
      {8'h7E, 8'h7E, 1'b0, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_tx(input logic [DW-1:0] d, input logic last);
      tx_valid = 1'b1; tx_data = d; tx_last = last;
      @(negedge clk);
      tx_valid = 1'b0; tx_last = 1'b0;
   endtask

   task automatic send_rx(input logic [DW-1:0] d, input logic ferr);
      rx_valid = 1'b1; rx_data = d; rx_frame_err = ferr;
      @(negedge clk);
      rx_valid = 1'b0; rx_frame_err = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 drv_en", 32'(drv_en), 0);
      chk("R1 echo_mode", 32'(echo_mode), 0);
      chk("R1 dout_valid", 32'(dout_valid), 0);
      chk("R1 flags", {30'd0, collision_flag, timeout_flag}, 0);

      // Single-byte messages from the vector table
      for (int i = 0; i < 6; i++) begin
         send_tx(VECS[i][17:10], 1'b1);
         chk($sformatf("R2 drv_en vec%0d", i), 32'(drv_en), 1);
         chk($sformatf("R2 echo_mode vec%0d", i), 32'(echo_mode), 1);
         send_rx(VECS[i][9:2], VECS[i][1]);
         chk($sformatf("R3 no delivery vec%0d", i), 32'(dout_valid), 0);
         chk($sformatf("R4 release vec%0d", i), {30'd0, drv_en, echo_mode}, 0);
         chk($sformatf("R6_R7 collision vec%0d", i), 32'(collision_flag), 32'(VECS[i][0]));
      end

      // R11: in-order multi-byte message
      send_tx(8'h11, 1'b0);
      send_tx(8'h22, 1'b0);
      send_tx(8'h33, 1'b1);
      send_rx(8'h11, 1'b0);
      chk("R11 hold after first", 32'(drv_en), 1);
      send_rx(8'h22, 1'b0);
      chk("R11 hold after second", 32'(drv_en), 1);
      chk("R11 no collision mid", 32'(collision_flag), 0);
      send_rx(8'h33, 1'b0);
      chk("R4 release after last", 32'(drv_en), 0);
      chk("R11 in order clean", 32'(collision_flag), 0);

      // R11: swapped echo order
      send_tx(8'h11, 1'b0);
      send_tx(8'h22, 1'b1);
      send_rx(8'h22, 1'b0);
      send_rx(8'h11, 1'b0);
      chk("R11 swapped collision", 32'(collision_flag), 1);
      chk("R6 released despite collision", 32'(drv_en), 0);

      // R5 and R8 in normal mode
      send_rx(8'h55, 1'b0);
      chk("R5 dout_valid", 32'(dout_valid), 1);
      chk("R5 dout_data", 32'(dout_data), 32'h55);
      chk("R8 collision held", 32'(collision_flag), 1);
      @(negedge clk);
      chk("R5 one-cycle strobe", 32'(dout_valid), 0);
      send_rx(8'h66, 1'b1);
      chk("R5 frame error dropped", 32'(dout_valid), 0);
      send_tx(8'h9A, 1'b1);
      chk("R8 collision cleared", 32'(collision_flag), 0);
      send_rx(8'h9A, 1'b0);
      chk("R4 release 9A", 32'(drv_en), 0);

      // R10: fill the queue, offer one more
      send_tx(8'h01, 1'b0);
      send_tx(8'h02, 1'b0);
      send_tx(8'h03, 1'b0);
      chk("R10 not full at 3", 32'(pend_full), 0);
      send_tx(8'h04, 1'b0);
      chk("R10 full at 4", 32'(pend_full), 1);
      send_tx(8'h05, 1'b1);
      chk("R10 still full", 32'(pend_full), 1);
      send_rx(8'h01, 1'b0);
      chk("R10 room after echo", 32'(pend_full), 0);
      send_rx(8'h02, 1'b0);
      send_rx(8'h03, 1'b0);
      send_rx(8'h04, 1'b0);
      chk("R10 ignored last byte", 32'(drv_en), 1);
      chk("R10 no collision", 32'(collision_flag), 0);

      // R9: quiet window
      repeat (TO) @(negedge clk);
      chk("R9 held through window", 32'(drv_en), 1);
      chk("R9 flag not yet", 32'(timeout_flag), 0);
      @(negedge clk);
      chk("R9 forced release", {30'd0, drv_en, echo_mode}, 0);
      chk("R9 timeout flag", 32'(timeout_flag), 1);
      chk("R9 queue emptied", 32'(pend_full), 0);
      repeat (3) @(negedge clk);
      chk("R8 timeout held", 32'(timeout_flag), 1);
      send_tx(8'hC3, 1'b1);
      chk("R8 timeout cleared", 32'(timeout_flag), 0);
      send_rx(8'hC3, 1'b0);
      chk("R4 release C3", 32'(drv_en), 0);
      chk("R9 clean after flush", 32'(collision_flag), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule